// File: doc/BRIEF.md
# CAN Bit Timing Synchronizer

This block lays out each bit on a CAN bus as a run of time quanta. A quantum tick, produced by a baud prescaler outside the block, advances a position counter through four segments in fixed order: a one-quantum synchronization slot, a propagation segment, a first phase buffer and a second phase buffer. The receive line is sampled at the boundary between the two phase buffers. A strobe marks the sample and another marks the start of each new bit.

The block keeps its bit grid aligned to the transmitter by watching for recessive-to-dominant transitions on the receive line. An edge that arrives later than the synchronization slot lengthens the first phase buffer. An edge that arrives early, inside the second phase buffer, shortens that buffer. Each correction is limited to the programmed jump width. While the bus is idle, a hard-sync request makes any falling edge restart the bit at once.

The segment lengths arrive as static inputs. An illegal combination raises an error flag and holds the timing parked, with every strobe silenced.

Top module: `can_bit_sync`

## Requirements
- R1: After reset, or after any bit start, with no edge, the sample strobe follows the tick numbered 1+PROP+PH1 and the bit-start strobe follows the tick numbered 1+PROP+PH1+PH2. Ticks are counted from 1, starting with the first tick after the bit start, and every length is a plain binary count of quanta. After reset both strobes are low and bit_val is 1 (recessive).
- R2: The sample and bit-start strobes are one-clock pulses. Each appears in the clock after the edge that took the tq_tick, and the two never appear together.
- R3: bit_val takes the value of rx_bit (1 = recessive, 0 = dominant) at the sampling tick and holds it until the next sample.
- R4: An edge observed at a tick that ends a propagation or first-phase quantum is late by the number of quanta since the synchronization slot ended. The first phase buffer grows by that error, capped at SJW.
- R5: An edge observed at a tick that ends a second-phase quantum is early by the number of second-phase quanta still left, including the current one. The second phase buffer shrinks by that error, capped at SJW.
- R6: An edge observed at the tick that ends the synchronization slot changes no timing.
- R7: An edge is a tick where rx_bit is 0 and was 1 at the previous tick. It resynchronizes only when bit_val is 1.
- R8: At most one resynchronization is applied per bit. Later edges in the same bit are ignored.
- R9: With hard_sync_en high, a falling edge starts a new bit at the synchronization slot. The bit-start strobe follows that same tick and no jump limit applies.
- R10: cfg_err rises one clock after the configuration is invalid. The configuration is invalid when any length is out of range (PROP 1..8, PH1 2..8, PH2 2..8, SJW 1..4), when PH1 < PH2, PH1 < SJW or PH2 < SJW, or when 1+PROP+PH1+PH2 is outside 8..25.
- R11: While cfg_err is high, no strobe is issued and the timing is parked at the synchronization slot. The first bit after the error clears follows the R1 schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tq_tick | input | 1 | One-clock pulse per time quantum |
| rx_bit | input | 1 | Synchronized receive bit, 1 = recessive |
| hard_sync_en | input | 1 | Bus idle: falling edges hard-synchronize |
| prop_len | input | 4 | Propagation segment length in quanta |
| ph1_len | input | 4 | First phase buffer length in quanta |
| ph2_len | input | 4 | Second phase buffer length in quanta |
| sjw_len | input | 3 | Jump width limit in quanta |
| bit_val | output | 1 | Last sampled bit |
| sample_stb | output | 1 | Sample point pulse |
| bit_start_stb | output | 1 | Bit start pulse |
| cfg_err | output | 1 | Configuration invalid |

## Verification
The assertions check the following on every cycle: the two strobes stay exclusive and always follow a quantum tick, bit_val moves only alongside a sample strobe, a sample falls within the legal tick window of its bit, and the outputs stay quiet during a configuration error. The directed scenarios show the exact tick positions. These cover the nominal grid, late and early corrections with and without the jump cap, edges in the synchronization slot, edges after a dominant sample, second edges in one bit, hard synchronization, and each configuration rule with its boundary values.

// File: rtl/can_bt_pkg.sv
`timescale 1ns/1ps
package can_bt_pkg;
    parameter int LEN_W   = 4;
    parameter int SJW_W   = 3;
    parameter int CNT_W   = LEN_W + 2;

    parameter int PROP_MIN = 1;
    parameter int PROP_MAX = 8;
    parameter int PH_MIN   = 2;
    parameter int PH_MAX   = 8;
    parameter int SJW_MIN  = 1;
    parameter int SJW_MAX  = 4;
    parameter int BIT_MIN  = 8;
    parameter int BIT_MAX  = 25;

    typedef enum logic [1:0] {
        SEG_SYNC = 2'd0,
        SEG_PROP = 2'd1,
        SEG_PH1  = 2'd2,
        SEG_PH2  = 2'd3
    } seg_e;

    typedef struct packed {
        seg_e             seg;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] ext;
        logic [CNT_W-1:0] cut;
        logic             adj_done;
        logic             bit_val;
        logic             smp;
        logic             start;
    } tm_state_t;
endpackage

// File: rtl/bt_cfg_check.sv
`timescale 1ns/1ps
module bt_cfg_check
    import can_bt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LEN_W-1:0] prop_len,
    input  logic [LEN_W-1:0] ph1_len,
    input  logic [LEN_W-1:0] ph2_len,
    input  logic [SJW_W-1:0] sjw_len,
    output logic             cfg_err
);
    localparam int SUM_W = LEN_W + 3;

    logic             err_d, err_q;
    logic [SUM_W-1:0] total;
    logic             bad_range, bad_order, bad_total;

    always_comb begin
        total = SUM_W'(1) + SUM_W'(prop_len) + SUM_W'(ph1_len) + SUM_W'(ph2_len);

        bad_range = (int'(prop_len) < PROP_MIN) || (int'(prop_len) > PROP_MAX) ||
                    (int'(ph1_len)  < PH_MIN)   || (int'(ph1_len)  > PH_MAX)   ||
                    (int'(ph2_len)  < PH_MIN)   || (int'(ph2_len)  > PH_MAX)   ||
                    (int'(sjw_len)  < SJW_MIN)  || (int'(sjw_len)  > SJW_MAX);

        bad_order = (ph1_len < ph2_len) ||
                    (ph1_len < LEN_W'(sjw_len)) ||
                    ((sjw_len >= SJW_W'(2)) && (ph2_len < LEN_W'(sjw_len))) ||
                    ((sjw_len == SJW_W'(1)) && (ph2_len < LEN_W'(2)));

        bad_total = (int'(total) < BIT_MIN) || (int'(total) > BIT_MAX);

        err_d = bad_range || bad_order || bad_total;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= err_d;
    end

    assign cfg_err = err_q;
endmodule

// File: rtl/bt_edge_det.sv
`timescale 1ns/1ps
module bt_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic tq_tick,
    input  logic rx_bit,
    input  logic hard_sync_en,
    input  logic prev_bit,
    input  logic adj_done,
    output logic resync_edge,
    output logic hard_edge
);
    logic rx_last_d, rx_last_q;
    logic fall;

    always_comb begin
        rx_last_d   = tq_tick ? rx_bit : rx_last_q;
        fall        = tq_tick && rx_last_q && !rx_bit;
        hard_edge   = fall && hard_sync_en;
        resync_edge = fall && !hard_sync_en && prev_bit && !adj_done;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_last_q <= 1'b1;
        else        rx_last_q <= rx_last_d;
    end
endmodule

// File: rtl/bt_phase_err.sv
`timescale 1ns/1ps
module bt_phase_err
    import can_bt_pkg::*;
(
    input  seg_e             seg,
    input  logic [CNT_W-1:0] cnt,
    input  logic [LEN_W-1:0] prop_len,
    input  logic [LEN_W-1:0] ph2_len,
    input  logic [SJW_W-1:0] sjw_len,
    output logic             late_hit,
    output logic             early_hit,
    output logic [CNT_W-1:0] late_amt,
    output logic [CNT_W-1:0] early_amt
);
    logic [CNT_W-1:0] late_raw, early_raw, sjw_w;

    always_comb begin
        sjw_w     = CNT_W'(sjw_len);
        late_raw  = '0;
        early_raw = '0;
        late_hit  = 1'b0;
        early_hit = 1'b0;
        case (seg)
            SEG_PROP: begin
                late_hit = 1'b1;
                late_raw = cnt + CNT_W'(1);
            end
            SEG_PH1: begin
                late_hit = 1'b1;
                late_raw = CNT_W'(prop_len) + cnt + CNT_W'(1);
            end
            SEG_PH2: begin
                early_hit = 1'b1;
                early_raw = CNT_W'(ph2_len) - cnt;
            end
            default: ;
        endcase
        late_amt  = (late_raw  > sjw_w) ? sjw_w : late_raw;
        early_amt = (early_raw > sjw_w) ? sjw_w : early_raw;
    end
endmodule

// File: rtl/bt_seg_ctrl.sv
`timescale 1ns/1ps
module bt_seg_ctrl
    import can_bt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tq_tick,
    input  logic             rx_bit,
    input  logic             cfg_err,
    input  logic             resync_edge,
    input  logic             hard_edge,
    input  logic             late_hit,
    input  logic             early_hit,
    input  logic [CNT_W-1:0] late_amt,
    input  logic [CNT_W-1:0] early_amt,
    input  logic [LEN_W-1:0] prop_len,
    input  logic [LEN_W-1:0] ph1_len,
    input  logic [LEN_W-1:0] ph2_len,
    output tm_state_t        st
);
    tm_state_t st_d, st_q;
    logic [CNT_W-1:0] ext_v, cut_v, nxt;
    logic             adj_v;

    always_comb begin
        st_d       = st_q;
        st_d.smp   = 1'b0;
        st_d.start = 1'b0;
        ext_v      = st_q.ext;
        cut_v      = st_q.cut;
        adj_v      = st_q.adj_done;
        nxt        = st_q.cnt + CNT_W'(1);

        if (cfg_err) begin
            st_d.seg      = SEG_SYNC;
            st_d.cnt      = '0;
            st_d.ext      = '0;
            st_d.cut      = '0;
            st_d.adj_done = 1'b0;
        end else if (tq_tick) begin
            if (hard_edge) begin
                st_d.seg      = SEG_SYNC;
                st_d.cnt      = '0;
                st_d.ext      = '0;
                st_d.cut      = '0;
                st_d.adj_done = 1'b0;
                st_d.start    = 1'b1;
            end else begin
                if (resync_edge && late_hit) begin
                    ext_v = late_amt;
                    adj_v = 1'b1;
                end
                if (resync_edge && early_hit) begin
                    cut_v = early_amt;
                    adj_v = 1'b1;
                end
                st_d.ext      = ext_v;
                st_d.cut      = cut_v;
                st_d.adj_done = adj_v;
                case (st_q.seg)
                    SEG_SYNC: begin
                        st_d.seg = SEG_PROP;
                        st_d.cnt = '0;
                    end
                    SEG_PROP: begin
                        if (nxt >= CNT_W'(prop_len)) begin
                            st_d.seg = SEG_PH1;
                            st_d.cnt = '0;
                        end else begin
                            st_d.cnt = nxt;
                        end
                    end
                    SEG_PH1: begin
                        if (nxt >= CNT_W'(ph1_len) + ext_v) begin
                            st_d.seg     = SEG_PH2;
                            st_d.cnt     = '0;
                            st_d.smp     = 1'b1;
                            st_d.bit_val = rx_bit;
                        end else begin
                            st_d.cnt = nxt;
                        end
                    end
                    SEG_PH2: begin
                        if (nxt + cut_v >= CNT_W'(ph2_len)) begin
                            st_d.seg      = SEG_SYNC;
                            st_d.cnt      = '0;
                            st_d.ext      = '0;
                            st_d.cut      = '0;
                            st_d.adj_done = 1'b0;
                            st_d.start    = 1'b1;
                        end else begin
                            st_d.cnt = nxt;
                        end
                    end
                    default: begin
                        st_d.seg = SEG_SYNC;
                        st_d.cnt = '0;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.seg      <= SEG_SYNC;
            st_q.bit_val  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign st = st_q;
endmodule

// File: rtl/can_bit_sync.sv
`timescale 1ns/1ps
module can_bit_sync
    import can_bt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tq_tick,
    input  logic             rx_bit,
    input  logic             hard_sync_en,
    input  logic [LEN_W-1:0] prop_len,
    input  logic [LEN_W-1:0] ph1_len,
    input  logic [LEN_W-1:0] ph2_len,
    input  logic [SJW_W-1:0] sjw_len,
    output logic             bit_val,
    output logic             sample_stb,
    output logic             bit_start_stb,
    output logic             cfg_err
);
    tm_state_t        st;
    logic             resync_edge, hard_edge;
    logic             late_hit, early_hit;
    logic [CNT_W-1:0] late_amt, early_amt;
    logic             err;

    bt_cfg_check u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .prop_len (prop_len),
        .ph1_len  (ph1_len),
        .ph2_len  (ph2_len),
        .sjw_len  (sjw_len),
        .cfg_err  (err)
    );

    bt_edge_det u_edge (
        .clk          (clk),
        .rst_n        (rst_n),
        .tq_tick      (tq_tick),
        .rx_bit       (rx_bit),
        .hard_sync_en (hard_sync_en),
        .prev_bit     (st.bit_val),
        .adj_done     (st.adj_done),
        .resync_edge  (resync_edge),
        .hard_edge    (hard_edge)
    );

    bt_phase_err u_perr (
        .seg       (st.seg),
        .cnt       (st.cnt),
        .prop_len  (prop_len),
        .ph2_len   (ph2_len),
        .sjw_len   (sjw_len),
        .late_hit  (late_hit),
        .early_hit (early_hit),
        .late_amt  (late_amt),
        .early_amt (early_amt)
    );

    bt_seg_ctrl u_seg (
        .clk         (clk),
        .rst_n       (rst_n),
        .tq_tick     (tq_tick),
        .rx_bit      (rx_bit),
        .cfg_err     (err),
        .resync_edge (resync_edge),
        .hard_edge   (hard_edge),
        .late_hit    (late_hit),
        .early_hit   (early_hit),
        .late_amt    (late_amt),
        .early_amt   (early_amt),
        .prop_len    (prop_len),
        .ph1_len     (ph1_len),
        .ph2_len     (ph2_len),
        .st          (st)
    );

    assign bit_val       = st.bit_val;
    assign sample_stb    = st.smp;
    assign bit_start_stb = st.start;
    assign cfg_err       = err;
endmodule

// File: rtl/bt_sync_chk.sv
`timescale 1ns/1ps
module bt_sync_chk (
    input logic clk,
    input logic rst_n,
    input logic tq_tick,
    input logic sample_stb,
    input logic bit_start_stb,
    input logic bit_val,
    input logic cfg_err
);
    logic [5:0] tk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              tk_q <= '0;
        else if (cfg_err)        tk_q <= '0;
        else if (bit_start_stb)  tk_q <= {5'b0, tq_tick};
        else if (tk_q != 6'd63)  tk_q <= tk_q + {5'b0, tq_tick};
    end

    a_r2_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_stb && bit_start_stb));

    a_r2_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb || bit_start_stb) |-> $past(tq_tick));

    a_r3_val_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bit_val) |-> sample_stb);

    a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_err && $past(cfg_err)) |-> (!sample_stb && !bit_start_stb));

    a_r1_sample_window: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> (tk_q >= 6'd4 && tk_q <= 6'd21));
endmodule

bind can_bit_sync bt_sync_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tq_tick       (tq_tick),
    .sample_stb    (sample_stb),
    .bit_start_stb (bit_start_stb),
    .bit_val       (bit_val),
    .cfg_err       (cfg_err)
);

// File: tb/sim_can_bit_sync.sv
`timescale 1ns/1ps
module sim_can_bit_sync;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tq_tick = 1'b0;
    logic       rx_bit = 1'b1;
    logic       hard_sync_en = 1'b0;
    logic [3:0] prop_len = 4'd2;
    logic [3:0] ph1_len = 4'd3;
    logic [3:0] ph2_len = 4'd3;
    logic [2:0] sjw_len = 3'd2;
    logic       bit_val, sample_stb, bit_start_stb, cfg_err;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    int first_smp, smp_val, first_st, last_st, n_smp, n_st;

    always #10 clk = ~clk;

    can_bit_sync u0 (
        .clk(clk), .rst_n(rst_n), .tq_tick(tq_tick), .rx_bit(rx_bit),
        .hard_sync_en(hard_sync_en), .prop_len(prop_len), .ph1_len(ph1_len),
        .ph2_len(ph2_len), .sjw_len(sjw_len), .bit_val(bit_val),
        .sample_stb(sample_stb), .bit_start_stb(bit_start_stb), .cfg_err(cfg_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // rx low for ticks lo_a..lo_b (when lo_a>0) and for tick lo_c
    task automatic run_ticks(input int n, input int lo_a, input int lo_b, input int lo_c);
        first_smp = 0; smp_val = -1; first_st = 0; last_st = 0; n_smp = 0; n_st = 0;
        for (int k = 1; k <= n; k++) begin
            rx_bit  = ((lo_a > 0 && k >= lo_a && k <= lo_b) || k == lo_c) ? 1'b0 : 1'b1;
            tq_tick = 1'b1;
            @(posedge clk); @(negedge clk);
            tq_tick = 1'b0;
            if (sample_stb) begin
                n_smp++;
                if (first_smp == 0) begin first_smp = k; smp_val = int'(bit_val); end
            end
            if (bit_start_stb) begin
                n_st++;
                if (first_st == 0) first_st = k;
                last_st = k;
            end
            @(posedge clk); @(negedge clk);
        end
    endtask

    task automatic set_cfg(input int p, input int a, input int b, input int s);
        prop_len = 4'(p); ph1_len = 4'(a); ph2_len = 4'(b); sjw_len = 3'(s);
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
    endtask

    task automatic expect_bit(input string req, input int smp, input int val, input int st);
        chk({req, " sample tick"}, first_smp, smp);
        chk({req, " sampled value"}, smp_val, val);
        chk({req, " start tick"}, first_st, st);
    endtask

    task automatic t_reset;
        chk("R1 reset sample_stb", int'(sample_stb), 0);
        chk("R1 reset bit_start_stb", int'(bit_start_stb), 0);
        chk("R1 reset bit_val", int'(bit_val), 1);
        chk("R10 reset cfg_err", int'(cfg_err), 0);
    endtask

    task automatic t_nominal;
        run_ticks(9, 0, 0, 0);  expect_bit("R1 first bit", 6, 1, 9);
        chk("R2 one sample per bit", n_smp, 1);
        run_ticks(9, 0, 0, 0);  expect_bit("R1 second bit", 6, 1, 9);
    endtask

    task automatic t_sync_edge;
        run_ticks(9, 1, 9, 0);  expect_bit("R6 edge in sync slot", 6, 0, 9);
        chk("R3 dominant held", int'(bit_val), 0);
        run_ticks(9, 2, 9, 0);  expect_bit("R7 edge after dominant sample", 6, 0, 9);
        run_ticks(9, 0, 0, 0);  expect_bit("R3 recessive sample", 6, 1, 9);
    endtask

    task automatic t_late;
        run_ticks(10, 2, 10, 0); expect_bit("R4 late by one", 7, 0, 10);
        run_ticks(9, 0, 0, 0);   expect_bit("R4 recover", 6, 1, 9);
        run_ticks(11, 4, 11, 0); expect_bit("R4 late capped", 8, 0, 11);
        run_ticks(9, 0, 0, 0);   expect_bit("R4 recover capped", 6, 1, 9);
    endtask

    task automatic t_early;
        run_ticks(8, 8, 8, 0);   expect_bit("R5 early by two", 6, 1, 8);
        run_ticks(9, 0, 0, 0);   expect_bit("R5 after early", 6, 1, 9);
        set_cfg(2, 3, 3, 1);
        run_ticks(8, 7, 7, 0);   expect_bit("R5 early capped", 6, 1, 8);
        set_cfg(2, 3, 3, 2);
        run_ticks(9, 0, 0, 0);   expect_bit("R5 after capped", 6, 1, 9);
    endtask

    task automatic t_once;
        run_ticks(10, 2, 2, 4);  expect_bit("R8 second edge ignored", 7, 1, 10);
    endtask

    task automatic t_hard;
        hard_sync_en = 1'b1;
        run_ticks(14, 5, 5, 0);
        chk("R9 hard restart tick", first_st, 5);
        chk("R9 sample after restart", first_smp, 11);
        chk("R9 next bit end", last_st, 14);
        chk("R9 bit starts", n_st, 2);
        hard_sync_en = 1'b0;
    endtask

    task automatic t_cfg;
        set_cfg(2, 3, 4, 2); chk("R10 PH1 below PH2", int'(cfg_err), 1);
        run_ticks(12, 0, 0, 0);
        chk("R11 no sample in error", n_smp, 0);
        chk("R11 no start in error", n_st, 0);
        set_cfg(2, 3, 3, 4); chk("R10 SJW above phases", int'(cfg_err), 1);
        set_cfg(2, 4, 2, 3); chk("R10 PH2 below SJW", int'(cfg_err), 1);
        set_cfg(3, 3, 1, 1); chk("R10 PH2 below two", int'(cfg_err), 1);
        set_cfg(1, 3, 2, 1); chk("R10 total seven", int'(cfg_err), 1);
        set_cfg(0, 4, 4, 2); chk("R10 PROP zero", int'(cfg_err), 1);
        set_cfg(2, 3, 3, 0); chk("R10 SJW zero", int'(cfg_err), 1);
        set_cfg(9, 8, 8, 4); chk("R10 PROP nine", int'(cfg_err), 1);
        set_cfg(2, 3, 2, 2); chk("R10 total eight legal", int'(cfg_err), 0);
        set_cfg(8, 8, 8, 4); chk("R10 total twenty-five legal", int'(cfg_err), 0);
        set_cfg(2, 3, 3, 2); chk("R10 base legal", int'(cfg_err), 0);
        run_ticks(9, 0, 0, 0); expect_bit("R11 restart after error", 6, 1, 9);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_nominal;
        t_sync_edge;
        t_late;
        t_early;
        t_once;
        t_hard;
        t_cfg;
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule